// File: doc/BRIEF.md
# Programmable Chip Select Decoder

The decoder turns each 32-bit bus address into exactly one of six active-low chip selects. Areas 1 to 5 are each described by a 16-bit base tag and a 16-bit don't-care mask. Both are compared with the upper half of the address, so an area starts on a 64 KB boundary. Setting mask bits widens an area to any power-of-two multiple of 64 KB. An address that falls in none of the five programmed areas selects area 0, the default region.

A small configuration port loads the tag and mask registers one at a time. Each write names an area index, chooses tag or mask, and supplies 16 data bits. After reset the five areas sit in consecutive 64 KB blocks from 0x00010000 up to 0x0005FFFF, and every mask is clear. While a bus cycle is valid, the block drives one chip select low and gates the active-low read strobe and the two write byte-lane strobes. When no cycle is valid, all outputs stay high.

Top module: `cs_decoder`

## Requirements
- R1: After reset, area k (k = 1 to 5) has tag value k and mask 0. Address 0x000k0000 to 0x000kFFFF therefore selects area k, and addresses 0x00000000 to 0x0000FFFF and 0x00060000 and above select area 0.
- R2: Area k matches when every upper-address bit (bits 31 to 16) whose mask bit is 0 equals the corresponding tag bit. Tag bits whose mask bit is 1 are ignored.
- R3: An address that matches none of areas 1 to 5 drives csN[0] low during a valid cycle.
- R4: When several areas match, only the lowest-numbered matching area drives its chip select low.
- R5: During a valid cycle, exactly one bit of csN is low, and bit i stands for area i. With busValid low, all csN bits, rdN and both wrN bits are high.
- R6: rdN is low exactly when busValid and busRead are both 1. wrN[b] is low exactly when busValid is 1, busRead is 0 and busWrLane[b] is 1.
- R7: A configuration write with cfgIdx 1 to 5 loads cfgData into that area's tag (cfgIsMask = 0) or mask (cfgIsMask = 1), and the decode uses the new value from the next clock edge on. A write with cfgIdx 0, 6 or 7 changes nothing.
- R8: Area k with tag 0x0FFF and mask 0x0003 covers exactly 0x0FFC0000 to 0x0FFFFFFF (256 KB). Area k with tag 0x0003 and mask 0 covers exactly 0x00030000 to 0x0003FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgIdx | input | 3 | Area index of the write (1 to 5 valid) |
| cfgIsMask | input | 1 | 0 writes the tag register, 1 writes the mask register |
| cfgData | input | 16 | Register write data |
| busValid | input | 1 | A bus cycle is in progress |
| busAddr | input | 32 | Bus address |
| busRead | input | 1 | 1 for a read cycle, 0 for a write cycle |
| busWrLane | input | 2 | Byte lanes written in a write cycle |
| csN | output | 6 | Active-low chip selects, bit i is area i |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 2 | Active-low write strobes per byte lane |

## Verification
A corrupted tag or mask register does not show until a bus address lands in the affected 64 KB window. From then on, the same combinational cycle shows the wrong csN bit low, so the bench biases addresses into and just outside every programmed window. A broken priority chain shows as two low chip selects, or as a higher-numbered area winning, but only when areas overlap, so overlaps are set up on purpose. A write that goes to the wrong register shows on the first access after the next clock edge.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int NUM_AREAS  = 5;
  localparam int ADDR_W     = 32;
  localparam int TAG_W      = 16;
  localparam int BYTE_LANES = 2;
  localparam int IDX_W      = $clog2(NUM_AREAS + 1) + ((NUM_AREAS + 1) == (1 << $clog2(NUM_AREAS + 1)) ? 1 : 0);
  localparam int CS_W       = NUM_AREAS + 1;

  typedef struct packed {
    logic [NUM_AREAS-1:0]  tagWe;
    logic [NUM_AREAS-1:0]  maskWe;
    logic                  busOn;
    logic                  rdOn;
    logic [BYTE_LANES-1:0] wrOn;
  } ctrlStrobes_t;
endpackage

// File: rtl/csd_ctrl.sv
module csd_ctrl
  import csd_pkg::*;
(
  input  logic                  cfgWrEn,
  input  logic [IDX_W-1:0]      cfgIdx,
  input  logic                  cfgIsMask,
  input  logic                  busValid,
  input  logic                  busRead,
  input  logic [BYTE_LANES-1:0] busWrLane,
  output ctrlStrobes_t          strb
);
  always_comb begin
    strb = '0;
    for (int k = 0; k < NUM_AREAS; k++) begin
      if (cfgWrEn && (cfgIdx == IDX_W'(k + 1))) begin
        strb.tagWe[k]  = !cfgIsMask;
        strb.maskWe[k] = cfgIsMask;
      end
    end
    strb.busOn = busValid;
    strb.rdOn  = busValid && busRead;
    strb.wrOn  = (busValid && !busRead) ? busWrLane : '0;
  end
endmodule

// File: rtl/csd_datapath.sv
module csd_datapath
  import csd_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobes_t                    strb,
  input  logic [TAG_W-1:0]                cfgData,
  input  logic [ADDR_W-1:0]               busAddr,
  output logic [CS_W-1:0]                 csN,
  output logic                            rdN,
  output logic [BYTE_LANES-1:0]           wrN,
  output logic [NUM_AREAS-1:0][TAG_W-1:0] tagQ,
  output logic [NUM_AREAS-1:0][TAG_W-1:0] maskQ
);
  logic [TAG_W-1:0]     addrTag;
  logic [NUM_AREAS-1:0] hit;
  logic [NUM_AREAS-1:0] grant;
  logic                 noHit;

  assign addrTag = busAddr[ADDR_W-1 -: TAG_W];

  for (genvar k = 0; k < NUM_AREAS; k++) begin : g_area
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagQ[k]  <= TAG_W'(k + 1);
        maskQ[k] <= '0;
      end else begin
        if (strb.tagWe[k])  tagQ[k]  <= cfgData;
        if (strb.maskWe[k]) maskQ[k] <= cfgData;
      end
    end
    assign hit[k] = (((addrTag ^ tagQ[k]) & ~maskQ[k]) == '0);
  end

  always_comb begin
    logic seen;
    seen  = 1'b0;
    grant = '0;
    for (int k = 0; k < NUM_AREAS; k++) begin
      grant[k] = hit[k] && !seen;
      seen     = seen || hit[k];
    end
    noHit = !seen;
  end

  assign csN = strb.busOn ? ~{grant, noHit} : '1;
  assign rdN = !strb.rdOn;
  assign wrN = ~strb.wrOn;
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import csd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [IDX_W-1:0]      cfgIdx,
  input  logic                  cfgIsMask,
  input  logic [TAG_W-1:0]      cfgData,
  input  logic                  busValid,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busRead,
  input  logic [BYTE_LANES-1:0] busWrLane,
  output logic [CS_W-1:0]       csN,
  output logic                  rdN,
  output logic [BYTE_LANES-1:0] wrN
);
  ctrlStrobes_t                    strb;
  logic [NUM_AREAS-1:0][TAG_W-1:0] tagRegs;
  logic [NUM_AREAS-1:0][TAG_W-1:0] maskRegs;

  csd_ctrl u_ctrl (
    .cfgWrEn   (cfgWrEn),
    .cfgIdx    (cfgIdx),
    .cfgIsMask (cfgIsMask),
    .busValid  (busValid),
    .busRead   (busRead),
    .busWrLane (busWrLane),
    .strb      (strb)
  );

  csd_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cfgData (cfgData),
    .busAddr (busAddr),
    .csN     (csN),
    .rdN     (rdN),
    .wrN     (wrN),
    .tagQ    (tagRegs),
    .maskQ   (maskRegs)
  );
endmodule

// File: rtl/csd_checker.sv
module csd_checker
  import csd_pkg::*;
(
  input logic                            clk,
  input logic                            rstN,
  input logic                            cfgWrEn,
  input logic [IDX_W-1:0]                cfgIdx,
  input logic                            cfgIsMask,
  input logic [TAG_W-1:0]                cfgData,
  input logic                            busValid,
  input logic [ADDR_W-1:0]               busAddr,
  input logic                            busRead,
  input logic [BYTE_LANES-1:0]           busWrLane,
  input logic [CS_W-1:0]                 csN,
  input logic                            rdN,
  input logic [BYTE_LANES-1:0]           wrN,
  input logic [NUM_AREAS-1:0][TAG_W-1:0] tagRegs,
  input logic [NUM_AREAS-1:0][TAG_W-1:0] maskRegs
);
  logic [NUM_AREAS-1:0] chkHit;
  always_comb begin
    for (int k = 0; k < NUM_AREAS; k++)
      chkHit[k] = (((busAddr[ADDR_W-1:ADDR_W-TAG_W] ^ tagRegs[k]) & ~maskRegs[k]) == '0);
  end

  p_one_cs_r5: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> ($countones(~csN) == 1));
  p_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (&csN && rdN && &wrN));
  p_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busRead) |-> (!rdN && &wrN));
  p_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busRead) |-> (rdN && (wrN == ~busWrLane)));
  p_fallback_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && (chkHit == '0)) |-> !csN[0]);
  p_badidx_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && ((cfgIdx == '0) || (cfgIdx > IDX_W'(NUM_AREAS)))) |=>
      ($stable(tagRegs) && $stable(maskRegs)));

  for (genvar k = 0; k < NUM_AREAS; k++) begin : g_chk
    localparam logic [NUM_AREAS-1:0] LOWER = NUM_AREAS'((1 << k) - 1);
    p_prio_r4: assert property (@(posedge clk) disable iff (!rstN)
      (busValid && !csN[k+1]) |-> (chkHit[k] && ((chkHit & LOWER) == '0)));
    p_tagwr_r7: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWrEn && !cfgIsMask && (cfgIdx == IDX_W'(k + 1))) |=>
        (tagRegs[k] == $past(cfgData)));
    p_maskwr_r7: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWrEn && cfgIsMask && (cfgIdx == IDX_W'(k + 1))) |=>
        (maskRegs[k] == $past(cfgData)));
  end
endmodule

bind cs_decoder csd_checker u_chk (.*);

// File: tb/tb_cs_decoder.sv
`timescale 1ns/1ps
module tb_cs_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgIdx = '0;
  logic        cfgIsMask = 1'b0;
  logic [15:0] cfgData = '0;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busRead = 1'b0;
  logic [1:0]  busWrLane = '0;
  logic [5:0]  csN;
  logic        rdN;
  logic [1:0]  wrN;

  int checks = 0;
  int fails = 0;
  logic [15:0] mTag [1:5];
  logic [15:0] mMask [1:5];

  always #2.5 clk = ~clk;

  cs_decoder dut (.*);

  function automatic int expArea(input logic [31:0] a);
    for (int k = 1; k <= 5; k++)
      if (((a[31:16] ^ mTag[k]) & ~mMask[k]) == 16'h0) return k;
    return 0;
  endfunction

  task automatic cfgWrite(input logic [2:0] idx, input logic isMask, input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIdx = idx; cfgIsMask = isMask; cfgData = d;
    @(posedge clk);
    #1;
    cfgWrEn = 1'b0;
    if (idx >= 1 && idx <= 5) begin
      if (isMask) mMask[idx] = d; else mTag[idx] = d;
    end
  endtask

  task automatic busCheck(input logic [31:0] a, input logic v, input logic r,
                          input logic [1:0] ln, input string req);
    logic [5:0] eCs;
    logic       eRd;
    logic [1:0] eWr;
    @(negedge clk);
    busValid = v; busAddr = a; busRead = r; busWrLane = ln;
    #1;
    eCs = v ? ~(6'b1 << expArea(a)) : 6'h3F;
    eRd = !(v && r);
    eWr = (v && !r) ? ~ln : 2'b11;
    checks++;
    if (csN !== eCs || rdN !== eRd || wrN !== eWr) begin
      fails++;
      $display("FAIL %s addr=%h csN=%b/%b rdN=%b/%b wrN=%b/%b (actual/expected)",
               req, a, csN, eCs, rdN, eRd, wrN, eWr);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] a;
    int j;
    for (int k = 1; k <= 5; k++) begin mTag[k] = 16'(k); mMask[k] = 16'h0; end
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R5 idle after reset
    busCheck(32'h0001_0000, 1'b0, 1'b1, 2'b11, "R5 idle");
    // R1 reset placement
    busCheck(32'h0000_FFFF, 1'b1, 1'b1, 2'b00, "R1 below area1");
    for (int k = 1; k <= 5; k++) begin
      busCheck({16'(k), 16'h0000}, 1'b1, 1'b1, 2'b00, "R1 area start");
      busCheck({16'(k), 16'hFFFF}, 1'b1, 1'b0, 2'b01, "R1 area end");
    end
    busCheck(32'h0006_0000, 1'b1, 1'b0, 2'b10, "R1 above area5");
    busCheck(32'hFFFF_FFFF, 1'b1, 1'b0, 2'b11, "R3 top of space");
    // R6 strobes
    busCheck(32'h0003_0004, 1'b1, 1'b0, 2'b00, "R6 write no lanes");
    busCheck(32'h0003_0004, 1'b0, 1'b0, 2'b11, "R6 invalid write");

    // R8 256 KB window in area 2
    cfgWrite(3'd2, 1'b0, 16'h0FFF);
    cfgWrite(3'd2, 1'b1, 16'h0003);
    busCheck(32'h0FFC_0000, 1'b1, 1'b1, 2'b00, "R8 window start");
    busCheck(32'h0FFF_FFFF, 1'b1, 1'b1, 2'b00, "R8 window end");
    busCheck(32'h0FFB_FFFF, 1'b1, 1'b1, 2'b00, "R8 below window");
    busCheck(32'h1000_0000, 1'b1, 1'b1, 2'b00, "R8 above window");
    busCheck(32'h0002_0000, 1'b1, 1'b1, 2'b00, "R2 old area2 gone");
    // R4 overlap: area1 moved onto area3
    cfgWrite(3'd1, 1'b0, 16'h0003);
    busCheck(32'h0003_8000, 1'b1, 1'b1, 2'b00, "R4 area1 wins over area3");
    busCheck(32'h0001_0000, 1'b1, 1'b1, 2'b00, "R8 old area1 now area0");
    // R4 wide area4 covers everything below
    cfgWrite(3'd4, 1'b1, 16'hFFFF);
    busCheck(32'h0005_0000, 1'b1, 1'b1, 2'b00, "R4 area4 beats area5");
    busCheck(32'h0003_0000, 1'b1, 1'b1, 2'b00, "R4 area1 beats area4");
    busCheck(32'h0000_0000, 1'b1, 1'b1, 2'b00, "R3 no area0 when area4 wide");
    cfgWrite(3'd4, 1'b1, 16'h0000);
    // R7 invalid indices ignored
    cfgWrite(3'd0, 1'b1, 16'hFFFF);
    cfgWrite(3'd6, 1'b0, 16'h0000);
    cfgWrite(3'd7, 1'b1, 16'hFFFF);
    busCheck(32'h0000_0000, 1'b1, 1'b1, 2'b00, "R7 bad index ignored");
    busCheck(32'h0005_1234, 1'b1, 1'b1, 2'b00, "R7 area5 unchanged");
    busCheck(32'h7000_0000, 1'b1, 1'b0, 2'b11, "R7 masks unchanged");
    // R7 write takes effect at next edge
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIdx = 3'd5; cfgIsMask = 1'b0; cfgData = 16'hABCD;
    busValid = 1'b1; busAddr = 32'hABCD_0000; busRead = 1'b1;
    #1;
    checks++;
    if (csN !== 6'b111110) begin
      fails++;
      $display("FAIL R7 before edge csN=%b expected=%b", csN, 6'b111110);
    end
    @(posedge clk); #1;
    cfgWrEn = 1'b0; mTag[5] = 16'hABCD;
    checks++;
    if (csN !== 6'b011111) begin
      fails++;
      $display("FAIL R7 after edge csN=%b expected=%b", csN, 6'b011111);
    end

    // R2 random mix
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 8) == 0)
        cfgWrite(3'($urandom % 8), 1'($urandom % 2),
                 ($urandom % 2) ? 16'($urandom % 16) : 16'($urandom));
      j = 1 + ($urandom % 5);
      if ($urandom % 2)
        a = {(mTag[j] & ~mMask[j]) | (16'($urandom) & mMask[j]), 16'($urandom)};
      else
        a = $urandom;
      if ($urandom % 4 == 0) a[16] = ~a[16];
      busCheck(a, ($urandom % 8) != 0, 1'($urandom % 2), 2'($urandom % 4), "R2 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule